// File: doc/BRIEF.md
# Mode-Selectable Memory Request Arbiter

This block decides which of four requestors owns a shared memory bus. The requestors are an urgent display fetch, the processor, the graphics engine and a background display fetch. Each one raises a request line and holds it for as long as it needs the bus. The arbiter answers with a one-hot grant.

The urgent display fetch always wins a decision. A single control input sets how the other three are ranked. When the input is low, the three share one priority level and take turns in round-robin order. When it is high, the ranking is fixed: the processor first, then graphics, then background display.

A grant is registered and stays in place until its owner drops its request. A new decision is made only when no grant is held.

Top module: `mem_req_arbiter`

## Requirements
- R1: The `gnt` output has at most one bit set in every cycle.
- R2: A grant bit turns on only if the matching `req` bit was high in the cycle before.
- R3: While the granted requestor keeps its request high, `gnt` stays the same on the next cycle. This holds even if `rr_off` or other requests change.
- R4: When the granted requestor drops its request, its grant is removed on the next clock edge. On that same edge the arbiter makes a new decision from the requests present, which gives zero if none are present.
- R5: A decision is a clock edge at which no held grant exists. At a decision with any `req` bit high, a grant is issued on that edge, so `gnt` changes one cycle after the request is seen.
- R6: Bit 0 (urgent display) wins every decision in which it requests, in both modes.
- R7: With `rr_off` = 1 (fixed ranking), the processor (bit 1) wins a decision over bits 2 and 3.
- R8: With `rr_off` = 1, graphics (bit 2) wins over background display (bit 3) when the processor is not requesting.
- R9: With `rr_off` = 0 (round robin), bits 1, 2 and 3 are searched in the cyclic order 1→2→3→1, starting just after the last of them to be granted.
- R10: A grant to bit 0 leaves the round-robin position unchanged. A grant to bits 1 to 3 moves the position in either mode.
- R11: A change of `rr_off` while a grant is held has no effect until the next decision.
- R12: Asynchronous active-low reset clears `gnt` to zero. It also sets the round-robin position so that the first search order is 1, 2, 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rr_off | input | 1 | 0 = round robin among bits 1 to 3; 1 = fixed ranking 1 > 2 > 3 |
| req | input | 4 | Requests: bit 0 urgent display, bit 1 processor, bit 2 graphics, bit 3 background display |
| gnt | output | 4 | One-hot grant, same bit order as `req` |

## Verification
The properties below are checked on every cycle:
- the grant is one-hot (R1);
- a grant goes only to a requestor that asked (R2);
- a held grant survives and a released one ends (R3, R4);
- a decision with pending requests always issues a grant (R5);
- the urgent request always wins (R6);
- the fixed ranking is respected (R7, R8).

Other behaviours depend on history and are shown only by the bench's scenarios:
- the round-robin rotation (R9);
- the round-robin position staying put across urgent grants (R10);
- a mode change taking effect only at the next decision (R11);
- the state of the position after reset (R12).

// File: rtl/mem_req_arbiter.sv
module mem_req_arbiter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rr_off,
  input  logic [3:0] req,
  output logic [3:0] gnt
);

  logic [1:0] last_q;
  logic [3:0] pick;
  logic       busy;

  assign busy = |(gnt & req);

  always_comb begin
    pick = 4'b0000;
    if (req[0]) begin
      pick = 4'b0001;
    end else if (rr_off) begin
      if      (req[1]) pick = 4'b0010;
      else if (req[2]) pick = 4'b0100;
      else if (req[3]) pick = 4'b1000;
    end else begin
      case (last_q)
        2'd1: begin
          if      (req[2]) pick = 4'b0100;
          else if (req[3]) pick = 4'b1000;
          else if (req[1]) pick = 4'b0010;
        end
        2'd2: begin
          if      (req[3]) pick = 4'b1000;
          else if (req[1]) pick = 4'b0010;
          else if (req[2]) pick = 4'b0100;
        end
        default: begin
          if      (req[1]) pick = 4'b0010;
          else if (req[2]) pick = 4'b0100;
          else if (req[3]) pick = 4'b1000;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt    <= 4'b0000;
      last_q <= 2'd3;
    end else if (!busy) begin
      gnt <= pick;
      if      (pick[1]) last_q <= 2'd1;
      else if (pick[2]) last_q <= 2'd2;
      else if (pick[3]) last_q <= 2'd3;
    end
  end

endmodule

// File: rtl/mem_req_arbiter_chk.sv
module mem_req_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rr_off,
  input logic [3:0] req,
  input logic [3:0] gnt
);

  logic dec;
  assign dec = ((gnt & req) == 4'b0000);

  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  p_grant_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((gnt & ~$past(gnt) & ~$past(req)) == 4'b0000));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dec |=> (gnt == $past(gnt)));

  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && gnt != 4'b0000) |=> ((gnt & $past(gnt)) == 4'b0000));

  p_no_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && req != 4'b0000) |=> (gnt != 4'b0000));

  p_urgent_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && req[0]) |=> (gnt == 4'b0001));

  p_cpu_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && rr_off && !req[0] && req[1]) |=> (gnt == 4'b0010));

  p_gfx_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && rr_off && req[1:0] == 2'b00 && req[2]) |=> (gnt == 4'b0100));

endmodule

bind mem_req_arbiter mem_req_arbiter_chk u_chk (.*);

// File: tb/mem_req_arbiter_test.sv
`timescale 1ns/1ps
module mem_req_arbiter_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rr_off = 1'b0;
  logic [3:0] req = 4'b0000;
  logic [3:0] gnt;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mem_req_arbiter uut (.clk(clk), .rst_n(rst_n), .rr_off(rr_off), .req(req), .gnt(gnt));

  // {requirement number, rr_off, req, expected gnt}; each row is applied for one edge.
  localparam int NV = 20;
  localparam logic [12:0] VEC [NV] = '{
    {4'd9,  1'b0, 4'b1110, 4'b0010}, // R9 first order 1,2,3
    {4'd3,  1'b0, 4'b1110, 4'b0010}, // R3 hold
    {4'd9,  1'b0, 4'b1100, 4'b0100}, // R9 after 1 comes 2
    {4'd3,  1'b0, 4'b1110, 4'b0100}, // R3 hold despite new request
    {4'd9,  1'b0, 4'b1010, 4'b1000}, // R9 after 2 comes 3
    {4'd6,  1'b0, 4'b0111, 4'b0001}, // R6 urgent wins
    {4'd10, 1'b0, 4'b0110, 4'b0010}, // R10 position still after 3
    {4'd9,  1'b0, 4'b0100, 4'b0100}, // R9
    {4'd11, 1'b1, 4'b0110, 4'b0100}, // R11 mode change mid-grant
    {4'd7,  1'b1, 4'b0010, 4'b0010}, // R7
    {4'd8,  1'b1, 4'b1100, 4'b0100}, // R8
    {4'd7,  1'b1, 4'b1010, 4'b0010}, // R7 fixed beats rotation
    {4'd5,  1'b1, 4'b1000, 4'b1000}, // R5
    {4'd4,  1'b0, 4'b0000, 4'b0000}, // R4 release to idle
    {4'd6,  1'b0, 4'b1111, 4'b0001}, // R6
    {4'd10, 1'b0, 4'b1110, 4'b0010}, // R10 after 3 comes 1
    {4'd4,  1'b0, 4'b0000, 4'b0000}, // R4
    {4'd9,  1'b0, 4'b1000, 4'b1000}, // R9 only 3 requests
    {4'd4,  1'b0, 4'b0000, 4'b0000}, // R4
    {4'd9,  1'b0, 4'b0110, 4'b0010}  // R9 after 3 comes 1
  };

  task automatic check(input int rq, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d gnt=%b expected=%b", rq, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(12, gnt, 4'b0000); // R12 reset state
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      rr_off = VEC[i][8];
      req    = VEC[i][7:4];
      @(negedge clk);
      check(int'(VEC[i][12:9]), gnt, VEC[i][3:0]);
    end
    // R12: reset mid-grant clears grant and restores position (last was 1)
    rst_n = 1'b0;
    #1;
    check(12, gnt, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
    req = 4'b1110;
    rr_off = 1'b0;
    @(negedge clk);
    check(12, gnt, 4'b0010);
    // R4: back-to-back handover on the release edge
    req = 4'b1100;
    @(negedge clk);
    check(4, gnt, 4'b0100);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule